// File: doc/BRIEF.md
# Sleep and Wake Controller

This block sequences the power state of a low-power receiver between a running state and a sleep state. Software asks for sleep with a one-cycle command strobe, or the system asks for it by driving an on/off control pin from high to low. Before it sleeps, the block raises a save request so that position and log data can be written to storage. It holds that request until an acknowledge arrives, or until a bounded wait runs out. The bound keeps the pin-driven path inside its latency budget.

While asleep, the block watches four wake sources, each enabled by one bit of a mask. The sources are: expiry of a programmed sleep duration, a long low level (a break) on the serial receive line, a rising edge on the on/off pin, and a qualified high pulse on a dedicated wake pin. All pin inputs pass through two-flop synchronizers. Pulse widths are measured in ticks of a prescaler driven by the system clock. On exit, a one-hot cause register records which source woke the block. A read strobe clears it.

The save request and acknowledge form the only handshake. The request stays high until the block is asleep, and the acknowledge is sampled only while a request is pending. All other pins are plain levels or strobes.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset the block is awake (`asleep`=0), `save_req`=0 and `wake_cause`=0.
- R2: A `sleep_cmd` strobe while awake raises `save_req`. The block stays awake while `save_req` is high and no acknowledge has come. The cycle after `save_ack` is sampled, `asleep` goes to 1 and `save_req` goes to 0.
- R3: A high-to-low transition on `onoff_pin` while awake starts the same save-then-sleep sequence as R2.
- R4: If no acknowledge arrives within SAVE_LIMIT ticks of raising `save_req`, the block enters sleep anyway. This bounds the delay from the on/off falling edge to sleep.
- R5: While asleep, a low-to-high transition on `onoff_pin` wakes the block when mask bit 2 is set. The recorded cause is 4'b0100.
- R6: While asleep, a complete low-high-low pulse on `wake_pin` whose high phase lasts at least QUAL_TICKS ticks wakes the block on the falling edge when mask bit 3 is set. The recorded cause is 4'b1000. A shorter pulse is ignored.
- R7: While asleep, `rxd_pin` held low for more than QUAL_TICKS ticks wakes the block when mask bit 1 is set. The recorded cause is 4'b0010. A shorter low is ignored.
- R8: A nonzero `sleep_ticks` value, captured at sleep entry, wakes the block after that many ticks when mask bit 0 is set. The recorded cause is 4'b0001. A value of zero disables this source.
- R9: A source whose mask bit is 0 does not wake the block.
- R10: `wake_cause` has at most one bit set. It is written only on a wake exit (the highest-numbered source wins when sources coincide) and holds its value until a `cause_rd` strobe clears it to zero.
- R11: A `sleep_cmd` strobe while asleep has no effect: `save_req` stays 0 and the block stays asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| sleep_cmd | input | 1 | One-cycle request to enter sleep |
| onoff_pin | input | 1 | Asynchronous on/off control level; a fall requests sleep, a rise wakes |
| wake_pin | input | 1 | Asynchronous wake pulse input |
| rxd_pin | input | 1 | Asynchronous serial receive line (idle high) |
| wake_mask | input | 4 | Source enables: bit0 timer, bit1 break, bit2 on/off rise, bit3 wake pulse |
| sleep_ticks | input | TMR_W | Sleep duration in ticks, captured at entry; zero disables |
| save_ack | input | 1 | Storage has finished the pre-sleep save |
| cause_rd | input | 1 | One-cycle strobe that clears the wake cause |
| save_req | output | 1 | Save request, high from the sleep request until sleep is entered |
| asleep | output | 1 | High while in the sleep state |
| wake_cause | output | 4 | One-hot cause of the last wake, same bit order as the mask |

## Verification
A state machine stuck in or wrongly leaving the saving state shows at once as `save_req` and `asleep` both low, or as `save_req` high past the SAVE_LIMIT window. A detector that miscounts its ticks shows as a wake from a pulse or break that was too short, or as no wake from one that was long enough. Each such error appears within a few ticks of the pin edge. A faulty cause latch shows on `wake_cause` in the cycle `asleep` falls: wrong bit, several bits, or a bit whose source is masked.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;
  localparam int NSRC    = 4;
  localparam int SRC_TMR = 0;
  localparam int SRC_BRK = 1;
  localparam int SRC_ONF = 2;
  localparam int SRC_PLS = 3;

  typedef logic [NSRC-1:0] src_vec_t;

  typedef enum logic [1:0] {
    ST_AWAKE  = 2'd0,
    ST_SAVING = 2'd1,
    ST_SLEEP  = 2'd2
  } pwr_state_t;
endpackage

// File: rtl/pwr_sync_bank.sv
module pwr_sync_bank #(
  parameter int          N       = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_async,
  output logic [N-1:0] q_sync
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic stage1, stage2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1 <= RST_VAL[i];
        stage2 <= RST_VAL[i];
      end else begin
        stage1 <= d_async[i];
        stage2 <= stage1;
      end
    end
    assign q_sync[i] = stage2;
  end
endmodule

// File: rtl/pwr_tick_gen.sv
module pwr_tick_gen #(
  parameter int DIV = 50000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect
  import pwr_sleep_pkg::*;
#(
  parameter int QUAL_TICKS = 20,
  parameter int TMR_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             asleep,
  input  logic             load,
  input  logic [TMR_W-1:0] sleep_ticks,
  input  logic             wake_s,
  input  logic             rxd_s,
  input  logic             onoff_rise,
  output src_vec_t         events
);
  localparam int QW = $clog2(QUAL_TICKS + 2);
  localparam logic [QW-1:0] QUAL = QW'(QUAL_TICKS);

  // ---------------- qualified wake pulse ----------------
  logic          wake_q, armed;
  logic [QW-1:0] pcnt;
  logic          w_rise, w_fall;

  assign w_rise = wake_s & ~wake_q;
  assign w_fall = ~wake_s & wake_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q <= 1'b0;
      armed  <= 1'b0;
      pcnt   <= '0;
    end else begin
      wake_q <= wake_s;
      if (!asleep) begin
        armed <= 1'b0;
        pcnt  <= '0;
      end else if (w_rise) begin
        armed <= 1'b1;
        pcnt  <= '0;
      end else if (w_fall) begin
        armed <= 1'b0;
        pcnt  <= '0;
      end else if (armed && tick && pcnt < QUAL) begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end

  // ---------------- serial break ----------------
  logic [QW-1:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   bcnt <= '0;
    else if (!asleep || rxd_s)    bcnt <= '0;
    else if (tick && bcnt <= QUAL) bcnt <= bcnt + 1'b1;
  end

  // ---------------- sleep duration timer ----------------
  logic [TMR_W-1:0] rem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   rem <= '0;
    else if (load)                rem <= sleep_ticks;
    else if (!asleep)             rem <= '0;
    else if (tick && rem != '0)   rem <= rem - 1'b1;
  end

  always_comb begin
    events          = '0;
    events[SRC_TMR] = asleep && tick && (rem == TMR_W'(1));
    events[SRC_BRK] = asleep && tick && !rxd_s && (bcnt == QUAL);
    events[SRC_ONF] = asleep && onoff_rise;
    events[SRC_PLS] = asleep && armed && w_fall && (pcnt >= QUAL);
  end
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
  import pwr_sleep_pkg::*;
#(
  parameter int TICK_DIV   = 50000,
  parameter int QUAL_TICKS = 20,
  parameter int SAVE_LIMIT = 300,
  parameter int TMR_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_cmd,
  input  logic             onoff_pin,
  input  logic             wake_pin,
  input  logic             rxd_pin,
  input  logic [3:0]       wake_mask,
  input  logic [TMR_W-1:0] sleep_ticks,
  input  logic             save_ack,
  input  logic             cause_rd,
  output logic             save_req,
  output logic             asleep,
  output logic [3:0]       wake_cause
);
  localparam int SW = $clog2(SAVE_LIMIT + 1);
  localparam logic [SW-1:0] SLIM = SW'(SAVE_LIMIT);

  // bit0 onoff, bit1 wake, bit2 rxd
  logic [2:0] pins_s;
  pwr_sync_bank #(.N(3), .RST_VAL(3'b101)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({rxd_pin, wake_pin, onoff_pin}),
    .q_sync(pins_s)
  );

  logic tick;
  pwr_tick_gen #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  logic onoff_q, onoff_rise, onoff_fall;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) onoff_q <= 1'b1;
    else        onoff_q <= pins_s[0];
  end
  assign onoff_rise = pins_s[0] & ~onoff_q;
  assign onoff_fall = ~pins_s[0] & onoff_q;

  pwr_state_t    state, state_nx;
  logic [SW-1:0] scnt;
  logic          enter, leave;
  src_vec_t      events, hits, pick;

  pwr_wake_detect #(.QUAL_TICKS(QUAL_TICKS), .TMR_W(TMR_W)) u_det (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .asleep(state == ST_SLEEP), .load(enter), .sleep_ticks(sleep_ticks),
    .wake_s(pins_s[1]), .rxd_s(pins_s[2]), .onoff_rise(onoff_rise),
    .events(events)
  );

  assign hits = events & wake_mask;

  // highest-numbered source wins
  always_comb begin
    pick = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (hits[i]) pick = src_vec_t'(1) << i;
    end
  end

  assign enter = (state == ST_SAVING) && (save_ack || scnt == SLIM);
  assign leave = (state == ST_SLEEP) && (hits != '0);

  always_comb begin
    state_nx = state;
    case (state)
      ST_AWAKE:  if (sleep_cmd || onoff_fall) state_nx = ST_SAVING;
      ST_SAVING: if (enter)                   state_nx = ST_SLEEP;
      ST_SLEEP:  if (leave)                   state_nx = ST_AWAKE;
      default:                                state_nx = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_AWAKE;
      scnt       <= '0;
      wake_cause <= '0;
    end else begin
      state <= state_nx;
      if (state != ST_SAVING)          scnt <= '0;
      else if (tick && scnt != SLIM)   scnt <= scnt + 1'b1;
      if (leave)                       wake_cause <= pick;
      else if (cause_rd)               wake_cause <= '0;
    end
  end

  assign save_req = (state == ST_SAVING);
  assign asleep   = (state == ST_SLEEP);
endmodule

// File: rtl/pwr_sleep_ctrl_sva.sv
module pwr_sleep_ctrl_sva #(
  parameter int TICK_DIV   = 50000,
  parameter int SAVE_LIMIT = 300
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_cmd,
  input logic       save_req,
  input logic       asleep,
  input logic [3:0] wake_cause,
  input logic [3:0] wake_mask
);
  localparam int BOUND = (SAVE_LIMIT + 1) * TICK_DIV + 2;

  int unsigned req_cycles;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        req_cycles <= 0;
    else if (save_req) req_cycles <= req_cycles + 1;
    else               req_cycles <= 0;
  end

  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(save_req && asleep)) else $error("save_req while asleep"); // R2
  AST_SLEEP_VIA_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(save_req)) else $error("sleep without save"); // R2
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    save_req |=> (save_req || asleep)) else $error("save_req dropped"); // R2
  AST_SAVE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    req_cycles <= BOUND) else $error("save wait too long"); // R4
  AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wake_cause)) else $error("cause not one-hot"); // R10
  AST_CAUSE_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> ((wake_cause & $past(wake_mask)) != 4'b0)) else $error("exit cause bad"); // R9
  AST_CAUSE_ONLY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_cause != 4'b0 && !$stable(wake_cause)) |-> $fell(asleep)) else $error("cause set off exit"); // R10
  AST_CMD_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && sleep_cmd) |=> !save_req) else $error("cmd while asleep acted"); // R11
endmodule

bind pwr_sleep_ctrl pwr_sleep_ctrl_sva #(.TICK_DIV(TICK_DIV), .SAVE_LIMIT(SAVE_LIMIT)) u_sva (
  .clk(clk), .rst_n(rst_n), .sleep_cmd(sleep_cmd), .save_req(save_req),
  .asleep(asleep), .wake_cause(wake_cause), .wake_mask(wake_mask)
);

// File: tb/pwr_sleep_ctrl_bench.sv
module pwr_sleep_ctrl_bench;
  localparam int TD = 4, QT = 5, SL = 20, TW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_cmd = 0, onoff_pin = 1, wake_pin = 0, rxd_pin = 1;
  logic [3:0] wake_mask = 4'b1111;
  logic [TW-1:0] sleep_ticks = '0;
  logic save_ack = 0, cause_rd = 0;
  logic save_req, asleep;
  logic [3:0] wake_cause;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  pwr_sleep_ctrl #(.TICK_DIV(TD), .QUAL_TICKS(QT), .SAVE_LIMIT(SL), .TMR_W(TW)) u_pwr_sleep_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_cmd(sleep_cmd), .onoff_pin(onoff_pin),
    .wake_pin(wake_pin), .rxd_pin(rxd_pin), .wake_mask(wake_mask),
    .sleep_ticks(sleep_ticks), .save_ack(save_ack), .cause_rd(cause_rd),
    .save_req(save_req), .asleep(asleep), .wake_cause(wake_cause)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_asleep(input logic want, input int max);
    for (int i = 0; i < max; i++) begin
      if (asleep == want) break;
      @(negedge clk);
    end
  endtask

  task automatic strobe_cmd();
    sleep_cmd = 1; @(negedge clk); sleep_cmd = 0;
  endtask

  task automatic ack();
    save_ack = 1; @(negedge clk); save_ack = 0;
  endtask

  task automatic clear_cause();
    cause_rd = 1; @(negedge clk); cause_rd = 0;
  endtask

  task automatic enter_sleep(input string req);
    strobe_cmd();
    cycles(2);
    ack();
    cycles(1);
    chk(asleep == 1, req, asleep, 1);
  endtask

  task automatic t_reset();
    chk(asleep == 0 && save_req == 0 && wake_cause == 0, "R1",
        {asleep, save_req, wake_cause}, 0);
  endtask

  task automatic t_cmd();
    strobe_cmd();
    cycles(3);
    chk(save_req == 1, "R2 req", save_req, 1);
    cycles(15);
    chk(asleep == 0 && save_req == 1, "R2 waits ack", asleep, 0);
    ack();
    cycles(1);
    chk(asleep == 1 && save_req == 0, "R2 slept", {asleep, save_req}, 2);
  endtask

  task automatic t_cmd_ignored();
    strobe_cmd();
    cycles(3);
    chk(save_req == 0 && asleep == 1, "R11", {asleep, save_req}, 2);
  endtask

  task automatic t_pulse();
    wake_pin = 1; cycles(8); wake_pin = 0; cycles(40);
    chk(asleep == 1, "R6 short ignored", asleep, 1);
    wake_pin = 1; cycles(40); wake_pin = 0;
    wait_asleep(0, 20);
    chk(asleep == 0 && wake_cause == 4'b1000, "R6 wake", wake_cause, 8);
    cycles(20);
    chk(wake_cause == 4'b1000, "R10 held", wake_cause, 8);
    clear_cause();
    chk(wake_cause == 0, "R10 cleared", wake_cause, 0);
  endtask

  task automatic t_break();
    enter_sleep("R7 entry");
    rxd_pin = 0; cycles(12); rxd_pin = 1; cycles(40);
    chk(asleep == 1, "R7 short ignored", asleep, 1);
    rxd_pin = 0; wait_asleep(0, 80); rxd_pin = 1;
    chk(asleep == 0 && wake_cause == 4'b0010, "R7 wake", wake_cause, 2);
    clear_cause();
  endtask

  task automatic t_timer();
    sleep_ticks = 8'd10;
    enter_sleep("R8 entry");
    cycles(20);
    chk(asleep == 1, "R8 early", asleep, 1);
    wait_asleep(0, 60);
    chk(asleep == 0 && wake_cause == 4'b0001, "R8 expire", wake_cause, 1);
    clear_cause();
    sleep_ticks = 8'd0;
    enter_sleep("R8 entry zero");
    cycles(150);
    chk(asleep == 1, "R8 zero disables", asleep, 1);
    wake_pin = 1; cycles(40); wake_pin = 0;
    wait_asleep(0, 20);
    clear_cause();
  endtask

  task automatic t_onoff();
    onoff_pin = 0;
    cycles(5);
    chk(save_req == 1, "R3 req", save_req, 1);
    ack();
    cycles(1);
    chk(asleep == 1, "R3 slept", asleep, 1);
    cycles(10);
    onoff_pin = 1;
    wait_asleep(0, 10);
    chk(asleep == 0 && wake_cause == 4'b0100, "R5 wake", wake_cause, 4);
    clear_cause();
  endtask

  task automatic t_mask();
    wake_mask = 4'b0111;
    enter_sleep("R9 entry");
    wake_pin = 1; cycles(40); wake_pin = 0; cycles(30);
    chk(asleep == 1 && wake_cause == 0, "R9 masked", asleep, 1);
    rxd_pin = 0; wait_asleep(0, 80); rxd_pin = 1;
    chk(wake_cause == 4'b0010, "R9 enabled source", wake_cause, 2);
    clear_cause();
    wake_mask = 4'b1111;
  endtask

  task automatic t_timeout();
    strobe_cmd();
    cycles(50);
    chk(asleep == 0 && save_req == 1, "R4 still saving", asleep, 0);
    wait_asleep(1, 80);
    chk(asleep == 1 && save_req == 0, "R4 timeout sleep", asleep, 1);
    rxd_pin = 0; wait_asleep(0, 80); rxd_pin = 1;
    clear_cause();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
        finish_run();
      end
    end
  end

  initial begin
    cycles(3);
    rst_n = 1;
    cycles(2);
    t_reset();
    t_cmd();
    t_cmd_ignored();
    t_pulse();
    t_break();
    t_timer();
    t_onoff();
    t_mask();
    t_timeout();
    cycles(5);
    finish_run();
  end
endmodule